// File: doc/BRIEF.md
# Parallel Flash Programming Port

This block models the pin-level programming port of a small on-chip code flash of 2048 bytes. There is no address bus. An internal 11-bit byte pointer is cleared each time the reset/voltage pin leaves the low level and is stepped by one on each rising edge of an address-advance pin. A programmer selects an operation with four mode lines and then either reads the port (verify, signature) or pulses a write strobe (program, chip erase, lock bits) while the reset/voltage pin sits at the programming-voltage level.

Every strobed operation is self-timed. A cycle counter whose length is a parameter keeps `busy` high for the whole operation. While a byte write is in flight, a verify read of that byte returns bit 7 inverted, and the host can poll for completion that way. Programming can only clear bits, so a used byte can only be restored by a chip erase. Two lock bits, which only a chip erase clears, can block further programming and block verify reads.

The bidirectional data port is split into an input bus, an output bus and an output enable, for a pad cell outside the block.

Top module: `flash_prog_port`

## Requirements
- R1: After `rst`, the pointer is 000H, every byte reads FFH, both locks are clear, `busy` is 0 and `pin_oe` is 0 unless a read mode is selected.
- R2: The pointer clears to 000H on the clock after `rst_lvl` changes from low (0 or 3) to high (1) or programming voltage (2). It increments on each rising edge of `adv_pin` and wraps from 7FFH to 000H.
- R3: A write strobe (rising edge of `wr_strobe`) starts an operation only while `rst_lvl` is 2. With `rst_lvl` at 1 the strobe does nothing.
- R4: A strobe that starts an operation raises `busy` on the next clock, and `busy` stays high for exactly WRITE_CLKS cycles. Strobes that arrive while `busy` is high are ignored.
- R5: While a program operation is pending, a verify read at its address returns the written data with bit 7 inverted. After `busy` falls, it returns the stored byte.
- R6: Programming stores the bitwise AND of the old byte and `pin_din`, so bits only go from 1 to 0.
- R7: Chip erase (mode 1000) sets every byte to FFH and clears both lock bits when it completes.
- R8: Lock-1 (mode 1111) blocks program strobes, and verify still works. Lock-2 (mode 1100) alone blocks nothing. With both set, verify leaves `pin_oe` at 0.
- R9: Signature read (mode 0000) returns 1EH at 000H, 21H at 001H and FFH elsewhere, whatever the lock state.
- R10: A mode value outside 0111, 0011, 1000, 1111, 1100 and 0000 leaves `pin_oe` at 0 and ignores strobes. A low `rst_lvl` also keeps `pin_oe` at 0.
- R11: Verify (mode 0011) with `rst_lvl` at 1 or 2 sets `pin_oe` and drives the byte at the pointer onto `pin_dout`. Program uses mode 0111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-up state) |
| rst_lvl | input | 2 | Reset/voltage pin level: 0 low, 1 high, 2 programming voltage, 3 treated as low |
| adv_pin | input | 1 | Address-advance pin; a rising edge steps the pointer |
| wr_strobe | input | 1 | Write strobe; a rising edge starts the selected operation |
| mode_sel | input | 4 | Operation select lines |
| pin_din | input | 8 | Data port, inbound half |
| pin_dout | output | 8 | Data port, outbound half |
| pin_oe | output | 1 | Data port output enable |
| busy | output | 1 | Self-timed operation in progress |

## Verification
A wrong pointer shows up as a wrong byte or signature on the very next verify read after a clear or an advance, so the bench reads back immediately after each pointer move, including across the 7FFH wrap. A wrong timer or pending-write state shows up as a `busy` run of the wrong length, or as a polled bit 7 that is not inverted during the write or stays inverted after it. Wrong lock or erase state is visible only on a later operation: a program that should be blocked raises `busy`, or a verify drives the port when it should not. For that reason every lock change is followed by a strobe and a read.

// File: rtl/flashpp_pkg.sv
package flashpp_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        LVL_LOW  = 2'd0,
        LVL_HIGH = 2'd1,
        LVL_VPP  = 2'd2,
        LVL_RSVD = 2'd3
    } lvl_e;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_PROG,
        OP_READ,
        OP_ERASE,
        OP_LOCK1,
        OP_LOCK2,
        OP_SIG
    } op_e;

    localparam logic [3:0] MODE_PROG  = 4'b0111;
    localparam logic [3:0] MODE_READ  = 4'b0011;
    localparam logic [3:0] MODE_ERASE = 4'b1000;
    localparam logic [3:0] MODE_LOCK1 = 4'b1111;
    localparam logic [3:0] MODE_LOCK2 = 4'b1100;
    localparam logic [3:0] MODE_SIG   = 4'b0000;

    function automatic op_e decode_mode(input logic [3:0] m);
        case (m)
            MODE_PROG:  return OP_PROG;
            MODE_READ:  return OP_READ;
            MODE_ERASE: return OP_ERASE;
            MODE_LOCK1: return OP_LOCK1;
            MODE_LOCK2: return OP_LOCK2;
            MODE_SIG:   return OP_SIG;
            default:    return OP_NONE;
        endcase
    endfunction

    // Pin counts as raised when it is at logic high or programming voltage.
    function automatic logic level_is_up(input logic [1:0] l);
        return (l == LVL_HIGH) || (l == LVL_VPP);
    endfunction

    function automatic logic is_timed_op(input op_e op);
        return (op == OP_PROG) || (op == OP_ERASE) ||
               (op == OP_LOCK1) || (op == OP_LOCK2);
    endfunction

    function automatic logic [BYTE_W-1:0] sig_byte(input logic [1:0] a, input logic hi_zero);
        if (!hi_zero)  return 8'hFF;
        case (a)
            2'd0:    return 8'h1E;
            2'd1:    return 8'h21;
            default: return 8'hFF;
        endcase
    endfunction

endpackage

// File: rtl/flashpp_addr_ctr.sv
module flashpp_addr_ctr #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              step,
    output logic [ADDR_W-1:0] addr
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            addr <= '0;
        end else if (step) begin
            addr <= addr + 1'b1;   // natural wrap at the top
        end
    end
endmodule

// File: rtl/flashpp_timer.sv
module flashpp_timer #(
    parameter int WRITE_CLKS = 24000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = (WRITE_CLKS < 2) ? 1 : $clog2(WRITE_CLKS);

    logic [CW-1:0] remain;

    assign done = busy && (remain == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            remain <= '0;
        end else if (start && !busy) begin
            busy   <= 1'b1;
            remain <= CW'(WRITE_CLKS - 1);
        end else if (busy) begin
            if (remain == '0) begin
                busy <= 1'b0;
            end else begin
                remain <= remain - 1'b1;
            end
        end
    end
endmodule

// File: rtl/flashpp_store.sv
module flashpp_store
    import flashpp_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              commit,
    input  op_e               commit_op,
    input  logic [ADDR_W-1:0] commit_addr,
    input  logic [BYTE_W-1:0] commit_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    output logic              lock1,
    output logic              lock2
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [BYTE_W-1:0] cells [DEPTH];

    logic wipe;
    assign wipe = rst || (commit && (commit_op == OP_ERASE));

    always_ff @(posedge clk) begin
        if (wipe) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= '1;
            end
        end else if (commit && (commit_op == OP_PROG)) begin
            // cells can only be discharged; the old byte masks the new one
            cells[commit_addr] <= cells[commit_addr] & commit_data;
        end
    end

    always_ff @(posedge clk) begin
        if (wipe) begin
            lock1 <= 1'b0;
            lock2 <= 1'b0;
        end else if (commit) begin
            if (commit_op == OP_LOCK1) lock1 <= 1'b1;
            if (commit_op == OP_LOCK2) lock2 <= 1'b1;
        end
    end

    assign rd_data = cells[rd_addr];
endmodule

// File: rtl/flash_prog_port.sv
module flash_prog_port
    import flashpp_pkg::*;
#(
    parameter int ADDR_W     = 11,
    parameter int WRITE_CLKS = 24000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  rst_lvl,
    input  logic        adv_pin,
    input  logic        wr_strobe,
    input  logic [3:0]  mode_sel,
    input  logic [7:0]  pin_din,
    output logic [7:0]  pin_dout,
    output logic        pin_oe,
    output logic        busy
);
    localparam int SIG_HI_W = ADDR_W - 2;

    // pin edge detection
    logic lvl_up, lvl_up_q, adv_q, wr_q;
    logic lvl_rise, adv_rise, wr_rise;

    assign lvl_up   = level_is_up(rst_lvl);
    assign lvl_rise = lvl_up && !lvl_up_q;
    assign adv_rise = adv_pin && !adv_q;
    assign wr_rise  = wr_strobe && !wr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_up_q <= 1'b0;
            adv_q    <= 1'b0;
            wr_q     <= 1'b0;
        end else begin
            lvl_up_q <= lvl_up;
            adv_q    <= adv_pin;
            wr_q     <= wr_strobe;
        end
    end

    op_e op;
    assign op = decode_mode(mode_sel);

    // byte pointer
    logic [ADDR_W-1:0] cur_addr;

    flashpp_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
        .clk  (clk),
        .rst  (rst),
        .clr  (lvl_rise),
        .step (adv_rise),
        .addr (cur_addr)
    );

    // operation launch
    logic lock1, lock2;
    logic start_ok, done;

    assign start_ok = wr_rise && (rst_lvl == LVL_VPP) && !busy &&
                      is_timed_op(op) && !((op == OP_PROG) && lock1);

    flashpp_timer #(.WRITE_CLKS(WRITE_CLKS)) u_tmr (
        .clk   (clk),
        .rst   (rst),
        .start (start_ok),
        .busy  (busy),
        .done  (done)
    );

    op_e               pend_op;
    logic [ADDR_W-1:0] pend_addr;
    logic [BYTE_W-1:0] pend_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_op   <= OP_NONE;
            pend_addr <= '0;
            pend_data <= '0;
        end else if (start_ok) begin
            pend_op   <= op;
            pend_addr <= cur_addr;
            pend_data <= pin_din;
        end
    end

    // array and lock bits
    logic [BYTE_W-1:0] rd_data;

    flashpp_store #(.ADDR_W(ADDR_W)) u_store (
        .clk         (clk),
        .rst         (rst),
        .commit      (done),
        .commit_op   (pend_op),
        .commit_addr (pend_addr),
        .commit_data (pend_data),
        .rd_addr     (cur_addr),
        .rd_data     (rd_data),
        .lock1       (lock1),
        .lock2       (lock2)
    );

    // port read path
    logic polling;
    assign polling = busy && (pend_op == OP_PROG) && (pend_addr == cur_addr);

    always_comb begin
        pin_oe   = 1'b0;
        pin_dout = '1;
        if (lvl_up) begin
            case (op)
                OP_READ: begin
                    if (!(lock1 && lock2)) begin
                        pin_oe   = 1'b1;
                        pin_dout = polling ? {~pend_data[7], pend_data[6:0]} : rd_data;
                    end
                end
                OP_SIG: begin
                    pin_oe   = 1'b1;
                    pin_dout = sig_byte(cur_addr[1:0], cur_addr[ADDR_W-1 -: SIG_HI_W] == '0);
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/flashpp_checker.sv
module flashpp_checker
    import flashpp_pkg::*;
#(
    parameter int ADDR_W     = 11,
    parameter int WRITE_CLKS = 24000
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        rst_lvl,
    input logic              adv_pin,
    input logic [3:0]        mode_sel,
    input logic [7:0]        pin_dout,
    input logic              pin_oe,
    input logic              busy,
    input logic [ADDR_W-1:0] ctr
);
    logic adv_prev, up_prev;
    int   run_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            adv_prev <= 1'b0;
            up_prev  <= 1'b0;
            run_len  <= 0;
        end else begin
            adv_prev <= adv_pin;
            up_prev  <= level_is_up(rst_lvl);
            run_len  <= busy ? run_len + 1 : 0;
        end
    end

    logic adv_edge, clr_edge;
    assign adv_edge = adv_pin && !adv_prev;
    assign clr_edge = level_is_up(rst_lvl) && !up_prev;

    logic [ADDR_W-1:0] ctr_plus;
    assign ctr_plus = ctr + 1'b1;

    // R2: wrap from the top address
    p_ctr_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        (adv_edge && !clr_edge && (ctr == '1)) |=> (ctr == '0));

    // R2: single step per advance edge
    p_ctr_step_r2: assert property (@(posedge clk) disable iff (rst)
        (adv_edge && !clr_edge) |=> (ctr == $past(ctr_plus)));

    // R2: clear on level rise
    p_ctr_clear_r2: assert property (@(posedge clk) disable iff (rst)
        clr_edge |=> (ctr == '0));

    // R4: busy run length
    p_busy_len_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (run_len == WRITE_CLKS));

    // R10: no drive while the level pin is low
    p_oe_low_lvl_r10: assert property (@(posedge clk) disable iff (rst)
        !level_is_up(rst_lvl) |-> !pin_oe);

    // R10: no drive for non-read modes
    p_oe_mode_r10: assert property (@(posedge clk) disable iff (rst)
        ((mode_sel != MODE_READ) && (mode_sel != MODE_SIG)) |-> !pin_oe);

    // R9: first signature byte
    p_sig0_r9: assert property (@(posedge clk) disable iff (rst)
        ((mode_sel == MODE_SIG) && level_is_up(rst_lvl) && (ctr == '0))
            |-> (pin_oe && (pin_dout == 8'h1E)));
endmodule

bind flash_prog_port flashpp_checker #(
    .ADDR_W     (ADDR_W),
    .WRITE_CLKS (WRITE_CLKS)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .rst_lvl  (rst_lvl),
    .adv_pin  (adv_pin),
    .mode_sel (mode_sel),
    .pin_dout (pin_dout),
    .pin_oe   (pin_oe),
    .busy     (busy),
    .ctr      (cur_addr)
);

// File: tb/flash_prog_port_test.sv
module flash_prog_port_test;
    localparam int WC = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] rst_lvl = 2'd0;
    logic       adv_pin = 1'b0;
    logic       wr_strobe = 1'b0;
    logic [3:0] mode_sel = 4'b1010;
    logic [7:0] pin_din = 8'h00;
    logic [7:0] pin_dout;
    logic       pin_oe;
    logic       busy;

    always #2 clk = ~clk;

    flash_prog_port #(.ADDR_W(11), .WRITE_CLKS(WC)) uut (
        .clk(clk), .rst(rst), .rst_lvl(rst_lvl), .adv_pin(adv_pin),
        .wr_strobe(wr_strobe), .mode_sel(mode_sel), .pin_din(pin_din),
        .pin_dout(pin_dout), .pin_oe(pin_oe), .busy(busy)
    );

    // scoreboard item: kind 0 data+oe, 1 oe, 2 busy, 3 bench count
    typedef struct {
        string req;
        int    kind;
        int    expv;
        int    act;
    } item_t;

    item_t sb[$];
    int checks = 0;
    int failures = 0;
    bit finished = 0;

    task automatic exp_data(input string req, input int v);
        item_t it; it.req = req; it.kind = 0; it.expv = v; it.act = 0; sb.push_back(it);
    endtask
    task automatic exp_oe(input string req, input int v);
        item_t it; it.req = req; it.kind = 1; it.expv = v; it.act = 0; sb.push_back(it);
    endtask
    task automatic exp_busy(input string req, input int v);
        item_t it; it.req = req; it.kind = 2; it.expv = v; it.act = 0; sb.push_back(it);
    endtask
    task automatic exp_count(input string req, input int a, input int v);
        item_t it; it.req = req; it.kind = 3; it.expv = v; it.act = a; sb.push_back(it);
    endtask

    // monitor: samples one time unit after each falling edge
    always @(negedge clk) begin
        #1;
        while (sb.size() > 0) begin
            item_t it;
            int    a;
            it = sb.pop_front();
            case (it.kind)
                0: a = pin_oe ? int'(pin_dout) : -1;
                1: a = int'(pin_oe);
                2: a = int'(busy);
                default: a = it.act;
            endcase
            checks++;
            if (a != it.expv) begin
                failures++;
                $display("FAIL %s kind=%0d actual=%0h expected=%0h", it.req, it.kind, a, it.expv);
            end
        end
    end

    task automatic step();
        @(negedge clk);
    endtask

    task automatic pulse_adv();
        adv_pin = 1'b1; step();
        adv_pin = 1'b0; step();
    endtask

    task automatic clear_ctr();
        rst_lvl = 2'd0; step();
        rst_lvl = 2'd1; step();
    endtask

    // leaves the bench one falling edge after the strobe went high
    task automatic strobe_op(input logic [3:0] m, input logic [7:0] d);
        rst_lvl = 2'd2; mode_sel = m; pin_din = d;
        wr_strobe = 1'b1; step();
        wr_strobe = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) step();
        step();
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) step();
        rst = 1'b0; rst_lvl = 2'd1; step();

        // R1: power-up state
        exp_busy("R1", 0); exp_oe("R1", 0); step();
        mode_sel = 4'b0011; exp_data("R1", 8'hFF); step();

        // R4 / R5: program 5AH at 000H, poll, measure busy
        strobe_op(4'b0111, 8'h5A);
        exp_busy("R4", 1);
        mode_sel = 4'b0011; exp_data("R5", 8'hDA); step();
        n = 1;
        while (busy) begin n++; step(); end
        exp_count("R4", n, WC);
        exp_data("R5", 8'h5A); step();

        // R4: second strobe during busy ignored
        pulse_adv();
        strobe_op(4'b0111, 8'hF0);
        pin_din = 8'h00; step();
        wr_strobe = 1'b1; step();
        wr_strobe = 1'b0;
        wait_idle();
        mode_sel = 4'b0011; exp_data("R4", 8'hF0); step();

        // R6: bits only clear
        strobe_op(4'b0111, 8'h3C); wait_idle();
        mode_sel = 4'b0011; exp_data("R6", 8'h30); step();

        // R3: strobe at logic high does nothing
        pulse_adv();
        rst_lvl = 2'd1; mode_sel = 4'b0111; pin_din = 8'h00;
        wr_strobe = 1'b1; step(); wr_strobe = 1'b0;
        exp_busy("R3", 0); step();
        mode_sel = 4'b0011; exp_data("R3", 8'hFF); step();

        // R10: low level keeps port released; R2: rise clears pointer
        rst_lvl = 2'd0; exp_oe("R10", 0); step();
        rst_lvl = 2'd1; step();
        exp_data("R2", 8'h5A); step();

        // R2: walk to 7FFH, program it, wrap to 000H
        for (int i = 0; i < 2047; i++) pulse_adv();
        exp_data("R2", 8'hFF); step();
        strobe_op(4'b0111, 8'h11); wait_idle();
        mode_sel = 4'b0011; exp_data("R11", 8'h11); step();
        rst_lvl = 2'd1; pulse_adv();
        exp_data("R2", 8'h5A); step();

        // R10: unknown mode
        strobe_op(4'b1010, 8'h00);
        exp_busy("R10", 0); exp_oe("R10", 0); step();

        // R9: signature bytes
        clear_ctr();
        mode_sel = 4'b0000; exp_data("R9", 8'h1E); step();
        pulse_adv(); exp_data("R9", 8'h21); step();
        pulse_adv(); exp_data("R9", 8'hFF); step();

        // R8: lock-1 blocks programming, verify still works
        strobe_op(4'b1111, 8'h00); wait_idle();
        pulse_adv();
        strobe_op(4'b0111, 8'h00);
        exp_busy("R8", 0); step();
        mode_sel = 4'b0011; exp_data("R8", 8'hFF); step();

        // R7: erase restores array and clears locks
        strobe_op(4'b1000, 8'h00); wait_idle();
        clear_ctr();
        mode_sel = 4'b0011; exp_data("R7", 8'hFF); step();

        // R8: lock-2 alone blocks nothing
        strobe_op(4'b1100, 8'h00); wait_idle();
        strobe_op(4'b0111, 8'h77);
        exp_busy("R7", 1);
        wait_idle();
        mode_sel = 4'b0011; exp_data("R8", 8'h77); step();

        // R8: both locks stop verify; R9: signature unaffected
        strobe_op(4'b1111, 8'h00); wait_idle();
        rst_lvl = 2'd1; mode_sel = 4'b0011; exp_oe("R8", 0); step();
        mode_sel = 4'b0000; exp_data("R9", 8'h1E); step();

        // R7: erase lifts both locks
        strobe_op(4'b1000, 8'h00); wait_idle();
        rst_lvl = 2'd1; mode_sel = 4'b0011; exp_data("R7", 8'hFF); step();

        step(); step();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule